// File: doc/BRIEF.md
# Controller Register Front End with Interrupt Request

This block is the programmed-I/O face of a disk controller. A host reaches it through a window of eight consecutive I/O offsets, selected by the low three address bits. Even offsets 0 and 2 are reads and odd offsets 3, 5 and 7 are writes. Through them the host reads a 16-bit status word, loads a control word, and loads the two halves of a pointer to a command block in memory. The block does not fetch or run commands itself. It hands the pointer to a fetch engine and gives that engine a one-cycle start pulse.

A write to the control word is decoded as a prioritised action. The fetch-and-execute bit wins over everything else. Next comes interrupt enable, then device clear. A write that carries none of these three bits is an access error. The interrupt request is a level. It rises when interrupts are switched on while the controller is already ready. It also rises when the completion engine reports that a command has finished while interrupts are enabled. It stays high until the host acknowledges it or clears the device.

Top module: `dev_reg_front`

## Requirements
- R1: After reset the status word reads 0x8008 (only dual-density bit 15 and ready bit 3 set). The interrupt request, fetch start, access error, control word output and command-block address are all zero.
- R2: A read at offset 0 always returns zero. A read at offset 2 returns the status word, with bit 1 interrupt enabled, bit 2 active, bit 3 ready, bit 4 any error, bit 6 hard transfer error and bit 15 dual density. `rd_data` is zero for every other access.
- R3: A write at offset 5 loads the pointer high word and a write at offset 7 loads the pointer low word. `cb_addr` equals the low PTR_HI_W bits of the high word above the 16-bit low word.
- R4: A control write (offset 3) with bit 8 set gives a one-cycle `fetch_start` in the cycle after the write. In the same cycle the status shows active set, ready clear and both error bits clear. Bits 1 and 4 of that write are ignored: the pointer and the interrupt-enable bit are unchanged.
- R5: A control write with bit 8 clear and bit 1 set sets status bit 1. If ready was set and interrupt enable was clear before the write, `irq_req` is high in the next cycle.
- R6: Such an interrupt-enable write raises no request when interrupt enable is already set or when ready is clear.
- R7: A control write with bits 8 and 1 clear and bit 4 set returns the status word to 0x8008, zeroes both pointer halves and drops `irq_req`.
- R8: Any access at offset 1, 4 or 6, and any control write with none of bits 8, 1, 4 set, pulses `access_err` for one cycle in the following cycle and leaves status, pointer and interrupt request unchanged.
- R9: A `cmp_done` pulse clears active and sets ready. It sets error bit 4 when `cmp_err` or `cmp_hard` is high and bit 6 when `cmp_hard` is high. It raises `irq_req` if interrupt enable is set.
- R10: `irq_req` stays high until an `irq_ack` cycle, after which it is low. A new raise in the same cycle as the acknowledge wins.
- R11: `ctrl_word` holds the last value written at offset 3.
- R12: Status bit 15 is always set, and active and ready are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_addr | input | ADDR_W | Access offset; low three bits decoded |
| acc_wdata | input | DATA_W | Write data for odd offsets |
| rd_data | output | DATA_W | Read data, combinational |
| access_err | output | 1 | One-cycle pulse for an unhandled access |
| fetch_start | output | 1 | One-cycle start pulse to the command fetch engine |
| cb_addr | output | PTR_HI_W+16 | Command block address |
| ctrl_word | output | DATA_W | Last control word written |
| cmp_done | input | 1 | Completion engine finished a command |
| cmp_err | input | 1 | Finished command had an error |
| cmp_hard | input | 1 | Finished command had a hard transfer error |
| irq_ack | input | 1 | Host acknowledge of the interrupt request |
| irq_req | output | 1 | Level interrupt request |

## Verification
Several properties are checked on every cycle. Status bit 15 stays set. Active and ready are exclusive, and every start pulse coincides with an active, not-ready status. An unhandled offset is always followed by an access error, and the request level holds until it is acknowledged or cleared. The bench scenarios cover the priority decode of mixed control bits, and show that a repeated or not-ready interrupt enable raises nothing. They also show the error bits left by a finished command and that device clear empties the pointer, all observed through reads and the output ports.

// File: rtl/fr_pkg.sv
package fr_pkg;
  // Status word bit positions (software visible)
  localparam int ST_IE   = 1;
  localparam int ST_ACT  = 2;
  localparam int ST_RDY  = 3;
  localparam int ST_ERR  = 4;
  localparam int ST_HERR = 6;
  localparam int ST_DD   = 15;
  // Control word bit positions
  localparam int CW_IE   = 1;
  localparam int CW_AUTO = 2;
  localparam int CW_TEST = 3;
  localparam int CW_CLR  = 4;
  localparam int CW_STRM = 5;
  localparam int CW_FCE  = 8;
  // Offsets inside the eight-address window
  localparam logic [2:0] OFF_DATA   = 3'd0;
  localparam logic [2:0] OFF_STATUS = 3'd2;
  localparam logic [2:0] OFF_CTRL   = 3'd3;
  localparam logic [2:0] OFF_PHI    = 3'd5;
  localparam logic [2:0] OFF_PLO    = 3'd7;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_FETCH,
    ACT_IEN,
    ACT_CLEAR,
    ACT_BAD
  } ctl_act_e;
endpackage

// File: rtl/fr_addr_dec.sv
module fr_addr_dec #(
  parameter int ADDR_W = 3
) (
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              sel_data,
  output logic              sel_stat,
  output logic              sel_ctl,
  output logic              sel_phi,
  output logic              sel_plo,
  output logic              sel_bad
);
  import fr_pkg::*;

  logic [2:0] offs;
  assign offs = acc_addr[2:0];

  always_comb begin
    sel_data = 1'b0;
    sel_stat = 1'b0;
    sel_ctl  = 1'b0;
    sel_phi  = 1'b0;
    sel_plo  = 1'b0;
    sel_bad  = 1'b0;
    if (acc_valid) begin
      case (offs)
        OFF_DATA:   sel_data = 1'b1;
        OFF_STATUS: sel_stat = 1'b1;
        OFF_CTRL:   sel_ctl  = 1'b1;
        OFF_PHI:    sel_phi  = 1'b1;
        OFF_PLO:    sel_plo  = 1'b1;
        default:    sel_bad  = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fr_ctl_dec.sv
module fr_ctl_dec #(
  parameter int DATA_W = 16
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output fr_pkg::ctl_act_e  act
);
  import fr_pkg::*;

  // Priority: fetch, then interrupt enable, then clear
  always_comb begin
    act = ACT_NONE;
    if (wr_en) begin
      if (wdata[CW_FCE])      act = ACT_FETCH;
      else if (wdata[CW_IE])  act = ACT_IEN;
      else if (wdata[CW_CLR]) act = ACT_CLEAR;
      else                    act = ACT_BAD;
    end
  end
endmodule

// File: rtl/fr_status.sv
module fr_status #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_fetch,
  input  logic              do_ien,
  input  logic              do_clear,
  input  logic              done,
  input  logic              done_err,
  input  logic              done_hard,
  output logic [DATA_W-1:0] stat_q
);
  import fr_pkg::*;

  localparam logic [DATA_W-1:0] ST_RESET =
    (DATA_W'(1) << ST_DD) | (DATA_W'(1) << ST_RDY);

  logic [DATA_W-1:0] stat_d;
  logic              stat_en;

  assign stat_en = do_fetch | do_ien | do_clear | done;

  always_comb begin
    stat_d = stat_q;
    if (do_clear) begin
      stat_d = ST_RESET;
    end else begin
      if (done) begin
        stat_d[ST_ACT]  = 1'b0;
        stat_d[ST_RDY]  = 1'b1;
        stat_d[ST_ERR]  = done_err | done_hard;
        stat_d[ST_HERR] = done_hard;
      end
      if (do_fetch) begin
        stat_d[ST_ACT]  = 1'b1;
        stat_d[ST_RDY]  = 1'b0;
        stat_d[ST_ERR]  = 1'b0;
        stat_d[ST_HERR] = 1'b0;
      end
      if (do_ien) stat_d[ST_IE] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= ST_RESET;
    else if (stat_en) stat_q <= stat_d;
  end
endmodule

// File: rtl/fr_irq.sv
module fr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic ack,
  input  logic clr,
  output logic irq_q
);
  logic irq_d;
  logic irq_en;

  assign irq_en = raise | ack | clr;

  always_comb begin
    if (clr)        irq_d = 1'b0;
    else if (raise) irq_d = 1'b1;
    else            irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end
endmodule

// File: rtl/dev_reg_front.sv
module dev_reg_front #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int PTR_HI_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [DATA_W-1:0]      acc_wdata,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   access_err,
  output logic                   fetch_start,
  output logic [PTR_HI_W+15:0]   cb_addr,
  output logic [DATA_W-1:0]      ctrl_word,
  input  logic                   cmp_done,
  input  logic                   cmp_err,
  input  logic                   cmp_hard,
  input  logic                   irq_ack,
  output logic                   irq_req
);
  import fr_pkg::*;

  localparam int PLO_W = 16;

  logic sel_data, sel_stat, sel_ctl, sel_phi, sel_plo, sel_bad;
  ctl_act_e act;
  logic do_fetch, do_ien, do_clear, do_bad;
  logic [DATA_W-1:0] stat_q;
  logic irq_raise;

  logic [PTR_HI_W-1:0] phi_q, phi_d;
  logic [PLO_W-1:0]    plo_q, plo_d;
  logic                phi_en, plo_en;
  logic [DATA_W-1:0]   ctl_q;
  logic                fetch_q, aerr_q;

  fr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .acc_valid(acc_valid), .acc_addr(acc_addr),
    .sel_data(sel_data), .sel_stat(sel_stat), .sel_ctl(sel_ctl),
    .sel_phi(sel_phi), .sel_plo(sel_plo), .sel_bad(sel_bad)
  );

  fr_ctl_dec #(.DATA_W(DATA_W)) u_ctl (
    .wr_en(sel_ctl), .wdata(acc_wdata), .act(act)
  );

  assign do_fetch = (act == ACT_FETCH);
  assign do_ien   = (act == ACT_IEN);
  assign do_clear = (act == ACT_CLEAR);
  assign do_bad   = (act == ACT_BAD) | sel_bad;

  fr_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .do_fetch(do_fetch), .do_ien(do_ien), .do_clear(do_clear),
    .done(cmp_done), .done_err(cmp_err), .done_hard(cmp_hard),
    .stat_q(stat_q)
  );

  assign irq_raise = (do_ien & stat_q[ST_RDY] & ~stat_q[ST_IE]) |
                     (cmp_done & stat_q[ST_IE]);

  fr_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .raise(irq_raise), .ack(irq_ack), .clr(do_clear),
    .irq_q(irq_req)
  );

  // Pointer halves: next-state
  assign phi_en = sel_phi | do_clear;
  assign plo_en = sel_plo | do_clear;
  assign phi_d  = do_clear ? '0 : acc_wdata[PTR_HI_W-1:0];
  assign plo_d  = do_clear ? '0 : acc_wdata[PLO_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi_q <= '0;
      plo_q <= '0;
    end else begin
      if (phi_en) phi_q <= phi_d;
      if (plo_en) plo_q <= plo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl_q <= '0;
    else if (sel_ctl) ctl_q <= acc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
      aerr_q  <= 1'b0;
    end else begin
      fetch_q <= do_fetch;
      aerr_q  <= do_bad;
    end
  end

  assign rd_data     = sel_stat ? stat_q : '0;
  assign access_err  = aerr_q;
  assign fetch_start = fetch_q;
  assign cb_addr     = {phi_q, plo_q};
  assign ctrl_word   = ctl_q;
endmodule

// File: rtl/fr_regs_chk.sv
module fr_regs_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              access_err,
  input logic              fetch_start,
  input logic              cmp_done,
  input logic              irq_ack,
  input logic              irq_req,
  input logic [DATA_W-1:0] stat_q
);
  logic [2:0] offs;
  logic       ctl_wr, clr_wr, ien_wr, fce_wr;
  assign offs   = acc_addr[2:0];
  assign ctl_wr = acc_valid && offs == 3'd3;
  assign fce_wr = ctl_wr && acc_wdata[8];
  assign ien_wr = ctl_wr && !acc_wdata[8] && acc_wdata[1];
  assign clr_wr = ctl_wr && !acc_wdata[8] && !acc_wdata[1] && acc_wdata[4];

  assert_rd0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && offs == 3'd0 |-> rd_data == '0);

  assert_fetch_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> stat_q[2] && !stat_q[3]);

  assert_ien_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ien_wr && stat_q[3] && !stat_q[1] |=> irq_req);

  assert_bad_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (offs == 3'd1 || offs == 3'd4 || offs == 3'd6) |=> access_err);

  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done && !fce_wr |=> stat_q[3] && !stat_q[2]);

  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack && !clr_wr |=> irq_req);

  assert_clear_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && !cmp_done |=> !irq_req);

  assert_status_shape_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[15] && !(stat_q[2] && stat_q[3]));
endmodule

bind dev_reg_front fr_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_wdata(acc_wdata), .rd_data(rd_data), .access_err(access_err),
  .fetch_start(fetch_start), .cmp_done(cmp_done), .irq_ack(irq_ack),
  .irq_req(irq_req), .stat_q(stat_q)
);

// File: tb/dev_reg_front_tb.sv
module dev_reg_front_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic [2:0]  acc_addr;
  logic [15:0] acc_wdata;
  logic [15:0] rd_data;
  logic        access_err, fetch_start;
  logic [23:0] cb_addr;
  logic [15:0] ctrl_word;
  logic        cmp_done, cmp_err, cmp_hard, irq_ack, irq_req;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dev_reg_front u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .access_err(access_err),
    .fetch_start(fetch_start), .cb_addr(cb_addr), .ctrl_word(ctrl_word),
    .cmp_done(cmp_done), .cmp_err(cmp_err), .cmp_hard(cmp_hard),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One access cycle; returns after the capturing edge, away from it
  task automatic access(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_wdata = '0;
  endtask

  task automatic read_status(string req, logic [15:0] exp);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 3'd2;
    #1 chk(req, rd_data, exp);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic finish_cmd(logic e, logic h);
    @(negedge clk);
    cmp_done = 1'b1; cmp_err = e; cmp_hard = h;
    @(negedge clk);
    cmp_done = 1'b0; cmp_err = 1'b0; cmp_hard = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", irq_req, 0);
    chk("R1 fetch", fetch_start, 0);
    chk("R1 aerr", access_err, 0);
    chk("R1 ctrl", ctrl_word, 0);
    chk("R1 ptr", cb_addr, 0);
    read_status("R1 status", 16'h8008);
  endtask

  task automatic t_reads;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 3'd0;
    #1 chk("R2 offset0", rd_data, 0);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R2 offset0 no err", access_err, 0);
    #1 chk("R2 idle rd", rd_data, 0);
  endtask

  task automatic t_pointer;
    access(3'd5, 16'hAB12);
    chk("R3 high", cb_addr, 24'h120000);
    access(3'd7, 16'h3456);
    chk("R3 low", cb_addr, 24'h123456);
  endtask

  task automatic t_ien_ready;
    access(3'd3, 16'h0002);
    chk("R5 irq", irq_req, 1);
    chk("R11 ctrl", ctrl_word, 16'h0002);
    read_status("R5 status", 16'h800A);
  endtask

  task automatic t_ack_repeat;
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R10 ack", irq_req, 0);
    access(3'd3, 16'h0002);
    chk("R6 ie already set", irq_req, 0);
  endtask

  task automatic t_fetch_priority;
    access(3'd3, 16'h0112);
    chk("R4 start", fetch_start, 1);
    chk("R4 ptr kept", cb_addr, 24'h123456);
    chk("R4 no aerr", access_err, 0);
    @(negedge clk);
    chk("R4 one cycle", fetch_start, 0);
    read_status("R4 status", 16'h8006);
  endtask

  task automatic t_clear;
    access(3'd3, 16'h0010);
    chk("R7 ptr", cb_addr, 0);
    chk("R7 irq", irq_req, 0);
    read_status("R7 status", 16'h8008);
  endtask

  task automatic t_ien_not_ready_done;
    access(3'd3, 16'h0100);
    access(3'd3, 16'h0002);
    chk("R6 not ready", irq_req, 0);
    read_status("R6 status", 16'h8006);
    finish_cmd(1'b0, 1'b1);
    chk("R9 irq", irq_req, 1);
    read_status("R9 hard status", 16'h805A);
    finish_cmd(1'b0, 1'b0);
    chk("R10 held", irq_req, 1);
    read_status("R9 clean status", 16'h800A);
  endtask

  task automatic t_bad;
    access(3'd3, 16'h0028);
    chk("R8 ctrl none", access_err, 1);
    chk("R11 ctrl bad", ctrl_word, 16'h0028);
    @(negedge clk);
    chk("R8 one cycle", access_err, 0);
    chk("R8 irq kept", irq_req, 1);
    read_status("R8 status kept", 16'h800A);
    access(3'd1, 16'h0000); chk("R8 off1", access_err, 1);
    access(3'd4, 16'h0000); chk("R8 off4", access_err, 1);
    access(3'd6, 16'hFFFF); chk("R8 off6", access_err, 1);
    chk("R8 ptr kept", cb_addr, 0);
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_wdata = '0;
    cmp_done = 1'b0; cmp_err = 1'b0; cmp_hard = 1'b0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reads();
    t_pointer();
    t_ien_ready();
    t_ack_repeat();
    t_fetch_priority();
    t_clear();
    t_ien_not_ready_done();
    t_bad();
    access(3'd3, 16'h0010);
    chk("R7 clear drops irq", irq_req, 0);
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got 0 expected 1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule